// File: doc/BRIEF.md
# Latency-Slotted Writeback Queue

This block is the writeback stage of a microcoded arithmetic engine whose pipeline is exposed to the program. The engine has no scoreboard. Each issued instruction drops its functional-unit result into a small circular slot buffer. The slot it uses is as far ahead as the operation's latency, so the result matures a fixed number of issued instructions later. At every issue, the slot under the head pointer is handed to the register file. The destination named by the instruction being issued in that same cycle receives it, and then the head moves on.

The destination field of an instruction therefore does not say where its own result goes. It says where the result maturing now goes. The microcode compiler schedules destinations with this in mind. The vector-output instruction freezes the queue and holds the program counter. Idle cycles freeze it as well. A counter records how many times a result overwrote another result that was still waiting in a slot.

Top module: `wbq_top`

## Requirements
- R1: Operation latency is taken from the 4-bit opcode: 1 and 2 give 5, 3 gives 7, 4 and 5 give 2, 6 gives 3, 8 and 9 give 4, 10 to 15 give 2, and 0 (no-op) and 7 (vector output) insert nothing.
- R2: A result with latency L, issued with opcode not 0 or 7, appears on the write port (wb_en, wb_reg, wb_value) at the L-th following issue that advances the queue. It is written to the destination register of that later instruction.
- R3: An advancing issue with destination 0 makes no register write. The head slot is still cleared, so its value never reappears when the ring wraps.
- R4: An issue with opcode 7 writes no register, does not move the head, inserts nothing, and holds pc_step low. Every other issue raises pc_step.
- R5: After reset every slot is empty (reads zero), every register reads zero, the head is at slot 0 and the collision count is zero.
- R6: When an insert lands on a slot that still holds a waiting result, the newer result replaces it and the collision count rises by one. A latency-7 insert into the head slot being cleared in that same issue is not a collision.
- R7: A no-op advances the queue and inserts nothing. A later read of that slot delivers zero.
- R8: A cycle with issue_valid low changes no slot, no register, no head position and no count.
- R9: The read port returns the last value written to the addressed register, and register 0 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| issue_op | input | 4 | Opcode of the issued instruction |
| issue_dest | input | 7 | Destination field of the issued instruction |
| fu_result | input | 32 | Result computed for the issued instruction |
| rd_addr | input | 7 | Register file read address |
| rd_data | output | 32 | Register file read data |
| wb_en | output | 1 | A register write happens at this issue |
| wb_reg | output | 7 | Register being written |
| wb_value | output | 32 | Value being written (the matured slot) |
| pc_step | output | 1 | The program counter advances |
| collisions | output | 16 | Number of slot overwrites since reset |

## Verification
Each opcode is first issued alone into an empty ring and followed by no-ops. This separates a wrong latency entry from a wrong placement offset. Sequences with destination 0 and full-ring wraps show whether a discarded slot is really cleared. Vector-output instructions and idle cycles are then mixed into a pending delivery, which shows whether either one moves the head. A deliberate overlap of a latency-7 result and a later latency-5 result is used to check the overwrite order and the collision count. It also covers the latency-7 case that lands on the head slot. A long pseudo-random stream is then checked against an independent ring model, issue by issue, and ends with a full register file readback.

// File: rtl/wbq_pkg.sv
package wbq_pkg;

  typedef enum logic [3:0] {
    OPC_NOP  = 4'd0,  OPC_ADD  = 4'd1,  OPC_SUB  = 4'd2,  OPC_MUL  = 4'd3,
    OPC_ABS  = 4'd4,  OPC_FTOI = 4'd5,  OPC_ITOF = 4'd6,  OPC_EMIT = 4'd7,
    OPC_SIN  = 4'd8,  OPC_COS  = 4'd9,  OPC_GT   = 4'd10, OPC_EQ   = 4'd11,
    OPC_MOV  = 4'd12, OPC_SEL  = 4'd13, OPC_SGN  = 4'd14, OPC_RSQ  = 4'd15
  } wbq_op_e;

  // Cycles from issue to maturity; zero for ops that insert nothing.
  function automatic logic [3:0] op_latency(input logic [3:0] op);
    case (wbq_op_e'(op))
      OPC_MUL:           op_latency = 4'd7;
      OPC_ADD, OPC_SUB:  op_latency = 4'd5;
      OPC_SIN, OPC_COS:  op_latency = 4'd4;
      OPC_ITOF:          op_latency = 4'd3;
      OPC_NOP, OPC_EMIT: op_latency = 4'd0;
      default:           op_latency = 4'd2;
    endcase
  endfunction

  function automatic logic op_inserts(input logic [3:0] op);
    op_inserts = (op != OPC_NOP) && (op != OPC_EMIT);
  endfunction

endpackage

// File: rtl/wbq_ring.sv
module wbq_ring #(
  parameter int SLOTS = 7,
  parameter int XLEN  = 32,
  parameter int LW    = 3,
  localparam int HW   = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            ins_en,
  input  logic [LW-1:0]   ins_lat,
  input  logic [XLEN-1:0] ins_data,
  output logic [XLEN-1:0] head_data,
  output logic [HW-1:0]   head_idx,
  output logic            coll_evt
);

  localparam int SW = HW + 1;

  logic [XLEN-1:0] slot_q [SLOTS];
  logic [SLOTS-1:0] busy_q;
  logic [HW-1:0] head_q, head_nxt, tgt;

  // Modular add of head and latency: the new head plus latency-1.
  function automatic logic [HW-1:0] ring_add(input logic [HW-1:0] base,
                                             input logic [LW-1:0] off);
    logic [SW+LW-1:0] sum;
    sum = (SW+LW)'(base) + (SW+LW)'(off);
    if (sum >= (SW+LW)'(SLOTS)) sum = sum - (SW+LW)'(SLOTS);
    ring_add = HW'(sum);
  endfunction

  assign head_nxt  = (head_q == HW'(SLOTS-1)) ? '0 : head_q + HW'(1);
  assign tgt       = ring_add(head_q, ins_lat);
  assign head_data = slot_q[head_q];
  assign head_idx  = head_q;
  assign coll_evt  = step && ins_en && busy_q[tgt] && (tgt != head_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      busy_q <= '0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else if (step) begin
      slot_q[head_q] <= '0;
      busy_q[head_q] <= 1'b0;
      head_q         <= head_nxt;
      if (ins_en) begin
        slot_q[tgt] <= ins_data;
        busy_q[tgt] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wbq_regfile.sv
module wbq_regfile #(
  parameter int NREG = 128,
  parameter int XLEN = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RW-1:0]   raddr,
  output logic [XLEN-1:0] rdata
);

  logic [XLEN-1:0] mem_q [NREG];

  assign rdata = (raddr == '0) ? '0 : mem_q[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we && (waddr != '0)) begin
      mem_q[waddr] <= wdata;
    end
  end

endmodule

// File: rtl/wbq_top.sv
module wbq_top #(
  parameter int SLOTS = 7,
  parameter int XLEN  = 32,
  parameter int NREG  = 128,
  parameter int CW    = 16,
  localparam int RW   = $clog2(NREG),
  localparam int HW   = $clog2(SLOTS),
  localparam int LW   = $clog2(SLOTS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [3:0]      issue_op,
  input  logic [RW-1:0]   issue_dest,
  input  logic [XLEN-1:0] fu_result,
  input  logic [RW-1:0]   rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic            wb_en,
  output logic [RW-1:0]   wb_reg,
  output logic [XLEN-1:0] wb_value,
  output logic            pc_step,
  output logic [CW-1:0]   collisions
);
  import wbq_pkg::*;

  logic            step, ins_en, coll_evt;
  logic [LW-1:0]   lat;
  logic [XLEN-1:0] head_data;
  logic [HW-1:0]   head_idx;
  logic [CW-1:0]   coll_q;

  assign step   = issue_valid && (issue_op != OPC_EMIT);
  assign ins_en = step && op_inserts(issue_op);
  assign lat    = LW'(op_latency(issue_op));

  wbq_ring #(.SLOTS(SLOTS), .XLEN(XLEN), .LW(LW)) u_ring (
    .clk(clk), .rst_n(rst_n), .step(step), .ins_en(ins_en),
    .ins_lat(lat), .ins_data(fu_result),
    .head_data(head_data), .head_idx(head_idx), .coll_evt(coll_evt)
  );

  assign wb_en    = step && (issue_dest != '0);
  assign wb_reg   = issue_dest;
  assign wb_value = head_data;
  assign pc_step  = step;

  wbq_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wb_en), .waddr(wb_reg), .wdata(wb_value),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        coll_q <= '0;
    else if (coll_evt) coll_q <= coll_q + CW'(1);
  end
  assign collisions = coll_q;

endmodule

// File: rtl/wbq_checker.sv
module wbq_checker #(
  parameter int SLOTS = 7,
  parameter int XLEN  = 32,
  parameter int RW    = 7,
  parameter int CW    = 16,
  localparam int HW   = $clog2(SLOTS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic [3:0]      issue_op,
  input logic [RW-1:0]   rd_addr,
  input logic [XLEN-1:0] rd_data,
  input logic            pc_step,
  input logic [HW-1:0]   head_idx,
  input logic            coll_evt,
  input logic [CW-1:0]   collisions
);

  // R4: a vector-output issue leaves the head where it was
  a_r4_emit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_op == 4'd7) |=> $stable(head_idx));

  // R8: idle cycles leave head and count untouched
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> ($stable(head_idx) && $stable(collisions)));

  // R2: an advancing issue moves the head by one, wrapping at the ring size
  a_r2_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    pc_step |=> head_idx == (($past(head_idx) == HW'(SLOTS-1)) ? HW'(0)
                             : HW'($past(head_idx) + HW'(1))));

  // R6: each collision event raises the count by exactly one
  a_r6_coll_count: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> collisions == CW'($past(collisions) + CW'(1)));

  a_r6_coll_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !coll_evt |=> $stable(collisions));

  // R9: register 0 reads zero
  a_r9_reg0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == '0) |-> (rd_data == '0));

endmodule

bind wbq_top wbq_checker #(.SLOTS(SLOTS), .XLEN(XLEN), .RW(RW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
  .rd_addr(rd_addr), .rd_data(rd_data), .pc_step(pc_step),
  .head_idx(head_idx), .coll_evt(coll_evt), .collisions(collisions)
);

// File: tb/test_wbq_top.sv
`timescale 1ns/1ps
module test_wbq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [3:0]  issue_op = '0;
  logic [6:0]  issue_dest = '0;
  logic [31:0] fu_result = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        wb_en;
  logic [6:0]  wb_reg;
  logic [31:0] wb_value;
  logic        pc_step;
  logic [15:0] collisions;

  always #5 clk = ~clk;

  wbq_top i_wbq_top (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_dest(issue_dest), .fu_result(fu_result), .rd_addr(rd_addr),
    .rd_data(rd_data), .wb_en(wb_en), .wb_reg(wb_reg), .wb_value(wb_value),
    .pc_step(pc_step), .collisions(collisions)
  );

  typedef struct packed {
    logic        en;
    logic [6:0]  rg;
    logic [31:0] val;
    logic        stp;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] m_slot [7];
  bit          m_busy [7];
  int          m_head = 0;
  int          m_coll = 0;
  logic [31:0] m_rf [128];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lat_of(input int op);
    if (op == 3) return 7;
    if (op == 1 || op == 2) return 5;
    if (op == 8 || op == 9) return 4;
    if (op == 6) return 3;
    if (op == 0 || op == 7) return 0;
    return 2;
  endfunction

  // Driver: one issue per call, expected writeback pushed to the scoreboard
  task automatic issue(input int op, input int d, input logic [31:0] res);
    exp_t e;
    int   t, old;
    @(negedge clk);
    issue_valid = 1'b1; issue_op = 4'(op); issue_dest = 7'(d); fu_result = res;
    e = '0;
    if (op != 7) begin
      e.stp = 1'b1;
      e.en  = (d != 0);
      e.rg  = 7'(d);
      e.val = m_slot[m_head];
      if (d != 0) m_rf[d] = m_slot[m_head];
      old = m_head;
      m_slot[m_head] = '0; m_busy[m_head] = 0;
      m_head = (m_head + 1) % 7;
      if (op != 0) begin
        t = (m_head + lat_of(op) - 1) % 7;
        if (m_busy[t] && t != old) m_coll++;
        m_slot[t] = res; m_busy[t] = 1;
      end
    end
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    issue_valid = 1'b0;
    issue_op = 4'($urandom_range(15));
    issue_dest = 7'($urandom_range(1, 127));
    fu_result = $urandom;
    sb.push_back('0);
  endtask

  task automatic rd_chk(input int r, input logic [31:0] exp, input string tag);
    idle();
    rd_addr = 7'(r);
    #2;
    check(rd_data === exp, tag, rd_data, exp);
  endtask

  // Monitor: pops one expectation per driven cycle, away from the edge
  always @(negedge clk) begin
    exp_t e;
    #3;
    if (rst_n && sb.size() > 0) begin
      e = sb.pop_front();
      check(pc_step === e.stp, "R4 pc_step", {31'd0, pc_step}, {31'd0, e.stp});
      check(wb_en === e.en, "R2/R3 wb_en", {31'd0, wb_en}, {31'd0, e.en});
      if (e.en) begin
        check(wb_reg === e.rg, "R2 wb_reg", {25'd0, wb_reg}, {25'd0, e.rg});
        check(wb_value === e.val, "R2 wb_value", wb_value, e.val);
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < 7; i++) begin m_slot[i] = '0; m_busy[i] = 0; end
    for (int i = 0; i < 128; i++) m_rf[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R5: reset state
    rd_chk(5, 32'd0, "R5 reg5 after reset");
    rd_chk(127, 32'd0, "R5 reg127 after reset");
    check(collisions === 16'd0, "R5 collisions", {16'd0, collisions}, 32'd0);
    issue(0, 20, 32'h0);   // R5: empty head slot delivers zero
    rd_chk(20, 32'd0, "R5 empty slot");

    // R1/R2: each opcode alone, result lands after its latency
    for (int op = 1; op < 16; op++) begin
      if (op == 7) continue;
      issue(op, 0, 32'h100 + op);
      for (int k = 1; k < lat_of(op); k++) issue(0, 0, 32'hDEAD);
      issue(0, 40 + op, 32'hBEEF);
      rd_chk(40 + op, 32'h100 + op, "R1 latency per opcode");
    end
    check(collisions === 16'd0, "R6 no collision on lat7 head", {16'd0, collisions}, 32'd0);

    // R7: no-op leaves slot empty; value consumed once
    issue(12, 0, 32'h55);
    issue(0, 0, 32'h1);
    issue(0, 50, 32'h2);
    rd_chk(50, 32'h55, "R7 delivered once");
    issue(0, 50, 32'h3);
    rd_chk(50, 32'h0, "R7 no-op inserts nothing");

    // R3: discarded slot cleared, not seen after wrap
    issue(4, 0, 32'h77);
    issue(0, 0, 32'h0);
    issue(0, 0, 32'h0);
    for (int k = 0; k < 7; k++) issue(0, 60, 32'h0);
    rd_chk(60, 32'h0, "R3 discarded slot cleared");

    // R4: vector output freezes the queue
    issue(3, 0, 32'h33);
    for (int k = 0; k < 3; k++) issue(7, 61, 32'hABCD);
    for (int k = 0; k < 6; k++) issue(0, 0, 32'h0);
    issue(0, 62, 32'h0);
    rd_chk(61, 32'h0, "R4 emit writes nothing");
    rd_chk(62, 32'h33, "R4 emit holds head");

    // R8: idle cycles freeze the queue
    issue(1, 0, 32'h44);
    for (int k = 0; k < 4; k++) idle();
    for (int k = 0; k < 4; k++) issue(0, 0, 32'h0);
    issue(0, 63, 32'h0);
    rd_chk(63, 32'h44, "R8 idle holds head");

    // R6: lat-7 result overwritten by lat-5 result two issues later
    issue(3, 0, 32'h1111);
    issue(0, 0, 32'h0);
    issue(1, 0, 32'h2222);
    for (int k = 0; k < 4; k++) issue(0, 0, 32'h0);
    issue(0, 64, 32'h0);
    rd_chk(64, 32'h2222, "R6 later insert wins");
    check(collisions === 16'd1, "R6 collision count", {16'd0, collisions}, 32'd1);

    // R9: register 0 stays zero
    rd_chk(0, 32'd0, "R9 reg0");

    // R2: pseudo-random stream against the model
    lf = 32'h1F2E3D4C;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[27:25] == 3'd0) idle();
      else issue(int'(lf[3:0]), int'(lf[10:4]), {lf[15:0], lf[31:16]});
    end
    idle();
    check(collisions === 16'(m_coll), "R6 random collisions",
          {16'd0, collisions}, m_coll);
    for (int r = 0; r < 128; r++) rd_chk(r, m_rf[r], "R9 readback");

    idle();
    @(negedge clk);
    #4;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule